// File: doc/BRIEF.md
# LIN Header Assist Control Unit

This block holds the control and status logic that sits between the LIN bus pin, a UART receiver and a pulse-measuring timer. A byte-wide register port exposes one control register and one status register. The control register arms receive masking, picks master or slave operation, chooses when masking ends, and enables each interrupt source. The status register holds three event flags. Each flag is cleared by writing 1 to its own clear bit.

In slave mode, software writes the arm bit. From then on the UART sees an idle-high line and the timer sees the bus. This lets the timer measure the break and the sync field while the UART ignores them. Masking ends when the break is detected or when the sync-field measurement completes, depending on the select bit. In master mode the timer output is ORed onto the transmit line. Masking then ends when break generation completes. The break, sync-field and collision events come from the timer and a comparator as single-cycle pulses. One interrupt line combines the flags that are enabled.

Top module: `lin_hdr_ctl`

## Requirements
- R1: After reset both registers read 0x00 and `irq` is 0. `uart_rx` follows `bus_rx`, `tmr_in` is 1 and `bus_tx` follows `uart_tx`.
- R2: The control register (address 0) has this layout: bits 2..0 are the enables for collision (bit 2), break (bit 1) and sync-field (bit 0). Bit 3 is the read-only masked status. Bit 4 is the arm bit. Bit 5 is the unmask select. Bit 6 selects master mode (1) or slave mode (0). Bit 7 is the LIN enable. The arm bit always reads 0, and a write to bit 3 has no effect.
- R3: A control write with bit 7 = 1 and bit 4 = 1 starts masking on the next clock edge. While masked, `uart_rx` is 1, `tmr_in` equals `bus_rx` and control bit 3 reads 1.
- R4: In slave mode with select = 0, a break event ends masking on the next edge. A sync event does not end it.
- R5: In slave mode with select = 1, a sync event ends masking on the next edge. A break event does not end it.
- R6: In master mode with LIN enabled, `bus_tx` = `uart_tx` | `tmr_out`. A break event ends masking whatever the select bit holds, and a sync event does not end it.
- R7: While LIN is disabled, `uart_rx` = `bus_rx`, `tmr_in` = 1, `bus_tx` = `uart_tx`, and control bit 3 reads 0. Events are ignored, and any masking state is dropped.
- R8: The status register (address 1) holds flags at bit 0 (sync measured), bit 1 (break) and bit 2 (collision). Each flag is set on the edge after its event while LIN is enabled, and stays set until it is cleared.
- R9: Writing 1 to status bit 3, 4 or 5 clears flag 0, 1 or 2 on the next edge. Bits 7..3 always read 0.
- R10: When an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when some flag is set and its enable bit is 1.
- R12: While LIN is enabled, a control write leaves the mode bit unchanged. The other fields of that write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (0 control, 1 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt_sync | input | 1 | Sync-field measurement complete pulse |
| evt_break | input | 1 | Break detected / generated pulse |
| evt_coll | input | 1 | Bus collision pulse |
| bus_rx | input | 1 | Receive level from the bus pin |
| uart_rx | output | 1 | Receive input to the UART |
| tmr_in | output | 1 | Input to the measuring timer |
| uart_tx | input | 1 | Transmit data from the UART |
| tmr_out | input | 1 | Timer output for break generation |
| bus_tx | output | 1 | Transmit level to the bus pin |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes and events take effect on the first clock edge after they are presented, because every state element is a single flop. The paths `uart_rx`, `tmr_in`, `bus_tx`, `rdata` and `irq` are combinational from that state and from the current pins. Each result is therefore due one edge after the stimulus, and a pin change shows at once. The bench steps a reference model at each rising edge, using the inputs that were held before that edge. It compares every output one nanosecond after the edge, then changes the inputs, so both the registered and the combinational results are sampled where they are due.

// File: rtl/lin_hdr_pkg.sv
// Package: shared widths, bit positions and control-state type for the
// LIN header assist unit. Assumes a byte-wide register port.
package lin_hdr_pkg;
    localparam int DATA_W   = 8;
    localparam int NFLAG    = 3;
    // control register bit positions (software-visible layout)
    localparam int CB_EN    = 7;
    localparam int CB_MST   = 6;
    localparam int CB_SEL   = 5;
    localparam int CB_ARM   = 4;
    localparam int CB_MSKD  = 3;
    // status register: flags at [NFLAG-1:0], clear bits just above
    localparam int SB_CLR0  = NFLAG;
    // flag indices
    localparam int FL_SYNC  = 0;
    localparam int FL_BRK   = 1;
    localparam int FL_COLL  = 2;

    typedef struct packed {
        logic             en;
        logic             mst;
        logic             sel;
        logic [NFLAG-1:0] ie;
    } ctl_t;
endpackage

// File: rtl/lin_ctl_reg.sv
// Module: control register and receive-mask state.
// Assumes: a one-cycle write strobe; events are one-cycle pulses.
// The mode bit is frozen while LIN is enabled; the arm bit is not stored.
module lin_ctl_reg
    import lin_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_sync,
    input  logic              evt_break,
    output ctl_t              ctl,
    output logic              mask_q
);
    logic release_mask;

    // Decide whether the current event ends masking for the active mode.
    always_comb begin
        if (!ctl.en)
            release_mask = 1'b0;
        else if (ctl.mst)
            release_mask = evt_break;
        else
            release_mask = ctl.sel ? evt_sync : evt_break;
    end

    // Control fields: the mode updates only while LIN is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.en  <= wdata[CB_EN];
            ctl.sel <= wdata[CB_SEL];
            ctl.ie  <= wdata[NFLAG-1:0];
            if (!ctl.en)
                ctl.mst <= wdata[CB_MST];
        end
    end

    // Mask state: armed by a write, dropped on release or when LIN is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 1'b0;
        else if (wr_ctl && !wdata[CB_EN])
            mask_q <= 1'b0;
        else if (wr_ctl && wdata[CB_ARM])
            mask_q <= 1'b1;
        else if (!ctl.en || release_mask)
            mask_q <= 1'b0;
    end
endmodule

// File: rtl/lin_flag_bank.sv
// Module: event flags with per-flag write-one-to-clear.
// Assumes: set pulses count only while LIN is enabled; a set wins over a clear.
module lin_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lin_en,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (lin_en && set_evt[i])
                flags[i] <= 1'b1;
            else if (clr_req[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_path_mux.sv
// Module: combinational routing of the pin, UART and timer signals.
// Assumes: the idle level of every line is 1.
module lin_path_mux (
    input  logic lin_en,
    input  logic mst,
    input  logic mask_q,
    input  logic bus_rx,
    input  logic uart_tx,
    input  logic tmr_out,
    output logic masked,
    output logic uart_rx,
    output logic tmr_in,
    output logic bus_tx
);
    // Route receive to the UART or the timer, and merge the timer onto transmit.
    always_comb begin
        masked  = lin_en & mask_q;
        uart_rx = masked ? 1'b1 : bus_rx;
        tmr_in  = masked ? bus_rx : 1'b1;
        bus_tx  = uart_tx | (lin_en & mst & tmr_out);
    end
endmodule

// File: rtl/lin_hdr_ctl.sv
// Module: top of the LIN header assist unit. Decodes the register port,
// assembles read data and forms the combined interrupt.
// Assumes: reads are combinational; unused addresses read 0.
module lin_hdr_ctl #(
    parameter int                ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              evt_sync,
    input  logic              evt_break,
    input  logic              evt_coll,
    input  logic              bus_rx,
    output logic              uart_rx,
    output logic              tmr_in,
    input  logic              uart_tx,
    input  logic              tmr_out,
    output logic              bus_tx,
    output logic              irq
);
    import lin_hdr_pkg::*;

    ctl_t             ctl;
    logic             mask_q;
    logic             masked;
    logic             wr_ctl;
    logic             wr_stat;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] set_evt;
    logic [NFLAG-1:0] clr_req;

    // Register-port decode and event packing.
    always_comb begin
        wr_ctl           = wr_en && (addr == CTRL_ADDR);
        wr_stat          = wr_en && (addr == STAT_ADDR);
        set_evt          = '0;
        set_evt[FL_SYNC] = evt_sync;
        set_evt[FL_BRK]  = evt_break;
        set_evt[FL_COLL] = evt_coll;
        clr_req          = wr_stat ? wdata[SB_CLR0 +: NFLAG] : '0;
    end

    lin_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .wdata     (wdata),
        .evt_sync  (evt_sync),
        .evt_break (evt_break),
        .ctl       (ctl),
        .mask_q    (mask_q)
    );

    lin_flag_bank #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lin_en  (ctl.en),
        .set_evt (set_evt),
        .clr_req (clr_req),
        .flags   (flags)
    );

    lin_path_mux u_path (
        .lin_en  (ctl.en),
        .mst     (ctl.mst),
        .mask_q  (mask_q),
        .bus_rx  (bus_rx),
        .uart_tx (uart_tx),
        .tmr_out (tmr_out),
        .masked  (masked),
        .uart_rx (uart_rx),
        .tmr_in  (tmr_in),
        .bus_tx  (bus_tx)
    );

    // Read mux: arm and clear bits always read 0.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[CB_EN]       = ctl.en;
            rdata[CB_MST]      = ctl.mst;
            rdata[CB_SEL]      = ctl.sel;
            rdata[CB_MSKD]     = masked;
            rdata[NFLAG-1:0]   = ctl.ie;
        end else if (addr == STAT_ADDR) begin
            rdata[NFLAG-1:0]   = flags;
        end
    end

    // Combined interrupt from enabled flags.
    always_comb irq = |(flags & ctl.ie);
endmodule

// File: rtl/lin_hdr_ctl_chk.sv
// Checker: temporal properties of the LIN header assist unit, bound to the top.
module lin_hdr_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lin_en,
    input logic       mst,
    input logic       masked,
    input logic       bus_rx,
    input logic       uart_rx,
    input logic       tmr_in,
    input logic       evt_break,
    input logic       wr_stat,
    input logic [7:0] wdata,
    input logic [2:0] flags,
    input logic       irq
);
    // R3: while masked, the UART sees idle and the timer sees the bus.
    assert_mask_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> (uart_rx && tmr_in == bus_rx));
    // R7: while stopped, receive passes straight through and the timer idles.
    assert_off_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_en |-> (uart_rx == bus_rx && tmr_in && !masked));
    // R10: a break event sets its flag even against a clear.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_en && evt_break) |=> flags[1]);
    // R8: a flag stays set unless its clear bit is written.
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_stat && wdata[4])) |=> flags[1]);
    // R11: no interrupt without a pending flag.
    assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 3'b000));
    // R12: the mode bit is frozen while LIN is enabled.
    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lin_en |=> $stable(mst));
endmodule

bind lin_hdr_ctl lin_hdr_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lin_en    (ctl.en),
    .mst       (ctl.mst),
    .masked    (masked),
    .bus_rx    (bus_rx),
    .uart_rx   (uart_rx),
    .tmr_in    (tmr_in),
    .evt_break (evt_break),
    .wr_stat   (wr_stat),
    .wdata     (wdata),
    .flags     (flags),
    .irq       (irq)
);

// File: tb/test_lin_hdr_ctl.sv
module test_lin_hdr_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ev_sync = 1'b0, ev_brk = 1'b0, ev_coll = 1'b0;
    logic       bus_rx = 1'b1, uart_tx = 1'b1, tmr_out = 1'b0;
    logic       uart_rx, tmr_in, bus_tx, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    bit       m_en, m_mst, m_sel, m_mask;
    bit [2:0] m_ie, m_fl;

    always #2 clk = ~clk;   // 250 MHz

    lin_hdr_ctl i_lin_hdr_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_sync(ev_sync), .evt_break(ev_brk), .evt_coll(ev_coll),
        .bus_rx(bus_rx), .uart_rx(uart_rx), .tmr_in(tmr_in), .uart_tx(uart_tx),
        .tmr_out(tmr_out), .bus_tx(bus_tx), .irq(irq)
    );

    task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    // Advance the model by one edge using the inputs held before it.
    task automatic model_edge();
        bit rel, clr;
        bit [2:0] ev;
        if (!rst_n) begin
            m_en = 0; m_mst = 0; m_sel = 0; m_mask = 0; m_ie = 0; m_fl = 0;
            return;
        end
        ev  = {ev_coll, ev_brk, ev_sync};
        rel = m_en && ((m_mst || !m_sel) ? ev_brk : ev_sync);
        for (int i = 0; i < 3; i++) begin
            clr = wr_en && addr == 2'd1 && wdata[3+i];
            if (m_en && ev[i]) m_fl[i] = 1;
            else if (clr)      m_fl[i] = 0;
        end
        if (wr_en && addr == 2'd0) begin
            if (!wdata[7])     m_mask = 0;
            else if (wdata[4]) m_mask = 1;
            else if (rel)      m_mask = 0;
            if (!m_en) m_mst = wdata[6];
            m_en = wdata[7]; m_sel = wdata[5]; m_ie = wdata[2:0];
        end else if (!m_en || rel) begin
            m_mask = 0;
        end
    endtask

    task automatic compare();
        bit msk;
        logic [7:0] er;
        msk = m_en && m_mask;
        er  = (addr == 2'd0) ? {m_en, m_mst, m_sel, 1'b0, msk, m_ie} :
              (addr == 2'd1) ? {5'b0, m_fl} : 8'h00;
        chk("uart_rx", {7'b0, uart_rx}, {7'b0, msk ? 1'b1 : bus_rx});
        chk("tmr_in",  {7'b0, tmr_in},  {7'b0, msk ? bus_rx : 1'b1});
        chk("bus_tx",  {7'b0, bus_tx},  {7'b0, uart_tx | (m_en && m_mst && tmr_out)});
        chk("irq",     {7'b0, irq},     {7'b0, |(m_fl & m_ie)});
        chk("rdata",   rdata, er);
    endtask

    // One clock: model at the edge, compare just after, then release inputs.
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        wr_en = 0; ev_sync = 0; ev_brk = 0; ev_coll = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; addr = a; wdata = d; step();
    endtask

    task automatic rd(logic [1:0] a);
        addr = a; step();
    endtask

    task automatic ev(bit s, bit b, bit c);
        ev_sync = s; ev_brk = b; ev_coll = c; step();
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog got %0d exp 0", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values and pass-through
        tag = "R1";
        step(); step();
        rst_n = 1;
        rd(2'd0); rd(2'd1); bus_rx = 0; rd(2'd0); bus_rx = 1; rd(2'd2);
        // R2: layout; arm reads 0; bit 3 ignored (LIN off)
        tag = "R2";
        wr(2'd0, 8'h3F); rd(2'd0);
        // R3/R4: slave, select 0
        tag = "R3";
        wr(2'd0, 8'h90); bus_rx = 0; rd(2'd0); bus_rx = 1; rd(2'd0);
        tag = "R4";
        ev(1, 0, 0); rd(2'd0); ev(0, 1, 0); bus_rx = 0; rd(2'd0); bus_rx = 1;
        // R5: slave, select 1
        tag = "R5";
        wr(2'd0, 8'hB0); ev(0, 1, 0); bus_rx = 0; rd(2'd0); bus_rx = 1;
        ev(1, 0, 0); rd(2'd0);
        // R12: mode write ignored while enabled
        tag = "R12";
        wr(2'd0, 8'hD1); rd(2'd0); tmr_out = 1; uart_tx = 0; rd(2'd0);
        tmr_out = 0; uart_tx = 1;
        // R7: disable; events ignored; pass-through
        tag = "R7";
        wr(2'd1, 8'h38); wr(2'd0, 8'h00); ev(1, 1, 1); rd(2'd1);
        bus_rx = 0; rd(2'd0); bus_rx = 1;
        wr(2'd0, 8'h40); tmr_out = 1; uart_tx = 0; rd(2'd0);
        // R6: master, timer merged, break releases for either select
        tag = "R6";
        wr(2'd0, 8'hD0); rd(2'd0); tmr_out = 0; rd(2'd0); uart_tx = 1;
        ev(1, 0, 0); rd(2'd0); ev(0, 1, 0); rd(2'd0);
        wr(2'd0, 8'hF0); ev(1, 0, 0); ev(0, 1, 0); rd(2'd0);
        // R8: flags set and held
        tag = "R8";
        ev(0, 0, 1); rd(2'd1); rd(2'd1);
        // R9: individual clears, clear bits read 0
        tag = "R9";
        wr(2'd1, 8'h10); rd(2'd1); wr(2'd1, 8'hE8); rd(2'd1); wr(2'd1, 8'h20); rd(2'd1);
        // R10: set against clear, same cycle
        tag = "R10";
        ev_brk = 1; ev_sync = 1; wr(2'd1, 8'h38); rd(2'd1); wr(2'd1, 8'h38); rd(2'd1);
        // R11: interrupt gating
        tag = "R11";
        ev(0, 1, 0); wr(2'd0, 8'hC1); rd(2'd1); wr(2'd0, 8'hC2); rd(2'd1);
        ev(0, 0, 1); wr(2'd0, 8'hC4); wr(2'd1, 8'h20); rd(2'd1);
        wr(2'd0, 8'hC7); wr(2'd1, 8'h10); rd(2'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule